// File: doc/BRIEF.md
# Minimum Hamming Distance Class Matcher

This block decides which stored class template lies closest to a binary test feature map. For every class it counts the bit positions where the test map and that class's template differ, and it reports the class with the lowest count together with that count. Templates are already binary when they reach the block. There is exactly one template per class.

A start strobe captures the test map and begins a pass. The block then walks an external template memory one word per cycle, class by class. It adds the popcount of each word's XOR to a running total for the current class, and it keeps the best class seen so far. When the last class has been scored, a one-cycle valid pulse marks fresh results. The result outputs then keep their values until the next pass finishes.

Top module: `hamming_class_matcher`

## Requirements
- R1: While reset is high and in the cycle after it falls, `result_valid_o` and `tmpl_rd_o` are 0, and `best_class_o` and `best_count_o` are 0.
- R2: An accepted start produces a burst of NUM_CLASSES*WORDS consecutive read cycles, beginning in the cycle after the start edge. In each of these cycles `tmpl_rd_o` is 1 and `tmpl_addr_o` rises by one from 0. Address c*WORDS+w holds word w of class c, and word w covers map bits [w*WORD_BITS +: WORD_BITS]. Outside the burst, `tmpl_rd_o` is 0.
- R3: The reported count equals the number of set bits in (test map XOR winning template), in the range 0 to MAP_BITS.
- R4: The reported class is the one whose mismatch count is smallest over all classes.
- R5: When several classes share the smallest count, the lowest class index is reported.
- R6: `result_valid_o` is high for exactly one cycle. That cycle is the one after the (NUM_CLASSES*WORDS+1)th rising edge that follows the edge which accepted start.
- R7: `best_class_o` and `best_count_o` change only at the edge that raises `result_valid_o`, and hold in every other cycle.
- R8: A start seen while a pass is in progress, including its final scoring cycle, is ignored. A start in the valid cycle is accepted.
- R9: The test map is sampled only at the edge that accepts start. Later changes to `test_map_i` do not affect the result of that pass.
- R10: Template data is taken from `tmpl_data_i` in the cycle after the corresponding read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a matching pass |
| test_map_i | input | MAP_BITS | Binary test feature map |
| tmpl_rd_o | output | 1 | Template memory read request |
| tmpl_addr_o | output | ADDR_W | Template word address |
| tmpl_data_i | input | WORD_BITS | Template word, one cycle after request |
| result_valid_o | output | 1 | One-cycle result strobe |
| best_class_o | output | CLS_W | Index of the closest class |
| best_count_o | output | CNT_W | Mismatch count of that class |

## Verification
The result pulse for one pass and the acceptance of the next start can fall in the same cycle, because the sequencer becomes idle exactly when the result is published. The bench raises start with a new test map in the valid cycle. It checks that the reported winner still belongs to the old map and that the next burst begins at address 0 in the following cycle. Starts placed in the middle of the burst and in the final scoring cycle are also applied; there the bench checks that no extra read occurs and that the result is unchanged.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_FINISH = 2'd2
    } seq_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned count_width(input int unsigned bits);
        return $clog2(bits) + 1;
    endfunction

endpackage

// File: rtl/hm_popcount.sv
module hm_popcount #(
    parameter int unsigned W  = 16,
    parameter int unsigned OW = 5
) (
    input  logic [W-1:0]  bits_i,
    output logic [OW-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + OW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/hm_read_sequencer.sv
module hm_read_sequencer
    import hm_pkg::*;
#(
    parameter int unsigned NUM_CLASSES = 4,
    parameter int unsigned WORDS       = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start_i,
    output logic                                accept_o,
    output logic                                rd_o,
    output logic [idx_width(NUM_CLASSES*WORDS)-1:0] addr_o,
    output logic                                beat_valid_o,
    output logic [idx_width(WORDS)-1:0]         beat_word_o,
    output logic [idx_width(NUM_CLASSES)-1:0]   beat_class_o,
    output logic                                beat_last_o,
    output logic                                beat_final_o
);
    localparam int unsigned TOTAL  = NUM_CLASSES * WORDS;
    localparam int unsigned ADDR_W = idx_width(TOTAL);
    localparam int unsigned WIDX_W = idx_width(WORDS);
    localparam int unsigned CLS_W  = idx_width(NUM_CLASSES);
    localparam logic [WIDX_W-1:0] LAST_WORD  = WIDX_W'(WORDS - 1);
    localparam logic [CLS_W-1:0]  LAST_CLASS = CLS_W'(NUM_CLASSES - 1);

    seq_state_e        state_q;
    logic [WIDX_W-1:0] word_q;
    logic [CLS_W-1:0]  class_q;
    logic              at_last_word;
    logic              at_last_class;

    assign at_last_word  = (word_q == LAST_WORD);
    assign at_last_class = (class_q == LAST_CLASS);
    assign accept_o      = start_i && (state_q == SEQ_IDLE);
    assign rd_o          = (state_q == SEQ_RUN);
    assign addr_o        = ADDR_W'(class_q) * ADDR_W'(WORDS) + ADDR_W'(word_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            word_q  <= '0;
            class_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SEQ_RUN;
                        word_q  <= '0;
                        class_q <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (at_last_word) begin
                        word_q <= '0;
                        if (at_last_class) state_q <= SEQ_FINISH;
                        else               class_q <= class_q + 1'b1;
                    end else begin
                        word_q <= word_q + 1'b1;
                    end
                end
                SEQ_FINISH: state_q <= SEQ_IDLE;
                default:    state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Tag travelling alongside the one-cycle memory latency
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_valid_o <= 1'b0;
            beat_word_o  <= '0;
            beat_class_o <= '0;
            beat_last_o  <= 1'b0;
            beat_final_o <= 1'b0;
        end else begin
            beat_valid_o <= rd_o;
            beat_word_o  <= word_q;
            beat_class_o <= class_q;
            beat_last_o  <= at_last_word;
            beat_final_o <= at_last_word && at_last_class;
        end
    end

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        rd_o |-> (int'(addr_o) < TOTAL));
    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_o && $past(rd_o)) |-> (addr_o == $past(addr_o) + 1'b1));
    // R8
    finish_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_FINISH) |=> (state_q == SEQ_IDLE));
    // R8
    run_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_o && !(at_last_word && at_last_class)) |=> rd_o);
endmodule

// File: rtl/hm_min_tracker.sv
module hm_min_tracker
    import hm_pkg::*;
#(
    parameter int unsigned NUM_CLASSES = 4,
    parameter int unsigned MAP_BITS    = 64,
    parameter int unsigned WORD_BITS   = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 beat_valid_i,
    input  logic [idx_width(NUM_CLASSES)-1:0]    beat_class_i,
    input  logic                                 beat_last_i,
    input  logic                                 beat_final_i,
    input  logic [WORD_BITS-1:0]                 test_word_i,
    input  logic [WORD_BITS-1:0]                 tmpl_word_i,
    output logic                                 valid_o,
    output logic [idx_width(NUM_CLASSES)-1:0]    best_class_o,
    output logic [count_width(MAP_BITS)-1:0]     best_count_o
);
    localparam int unsigned CLS_W = idx_width(NUM_CLASSES);
    localparam int unsigned CNT_W = count_width(MAP_BITS);
    localparam int unsigned POP_W = count_width(WORD_BITS);

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic [CNT_W-1:0] cnt;
    } cand_t;

    logic [POP_W-1:0] word_pop;
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] class_sum;
    cand_t            run_q;
    cand_t            winner;
    logic             take_new;

    hm_popcount #(.W(WORD_BITS), .OW(POP_W)) u_pop (
        .bits_i  (test_word_i ^ tmpl_word_i),
        .count_o (word_pop)
    );

    assign class_sum = acc_q + CNT_W'(word_pop);
    // strict less-than keeps the earlier (lower) class on a tie
    assign take_new  = (beat_class_i == '0) || (class_sum < run_q.cnt);

    always_comb begin
        winner = run_q;
        if (take_new) begin
            winner.cls = beat_class_i;
            winner.cnt = class_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q        <= '0;
            run_q        <= '0;
            valid_o      <= 1'b0;
            best_class_o <= '0;
            best_count_o <= '0;
        end else begin
            valid_o <= 1'b0;
            if (beat_valid_i) begin
                if (beat_last_i) begin
                    acc_q <= '0;
                    run_q <= winner;
                    if (beat_final_i) begin
                        valid_o      <= 1'b1;
                        best_class_o <= winner.cls;
                        best_count_o <= winner.cnt;
                    end
                end else begin
                    acc_q <= class_sum;
                end
            end
        end
    end

    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(acc_q) <= MAP_BITS);
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(best_count_o) <= MAP_BITS);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_i && beat_final_i) |=> valid_o);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(best_class_o) && $stable(best_count_o)));
    // R5
    tie_keeps_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_i && beat_last_i && beat_final_i && beat_class_i != '0
         && class_sum == run_q.cnt) |=> (best_class_o == $past(run_q.cls)));
endmodule

// File: rtl/hamming_class_matcher.sv
module hamming_class_matcher
    import hm_pkg::*;
#(
    parameter int unsigned NUM_CLASSES = 4,
    parameter int unsigned MAP_BITS    = 64,
    parameter int unsigned WORD_BITS   = 16,
    localparam int unsigned WORDS  = MAP_BITS / WORD_BITS,
    localparam int unsigned ADDR_W = idx_width(NUM_CLASSES * WORDS),
    localparam int unsigned CLS_W  = idx_width(NUM_CLASSES),
    localparam int unsigned CNT_W  = count_width(MAP_BITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [MAP_BITS-1:0]  test_map_i,
    output logic                 tmpl_rd_o,
    output logic [ADDR_W-1:0]    tmpl_addr_o,
    input  logic [WORD_BITS-1:0] tmpl_data_i,
    output logic                 result_valid_o,
    output logic [CLS_W-1:0]     best_class_o,
    output logic [CNT_W-1:0]     best_count_o
);
    localparam int unsigned WIDX_W = idx_width(WORDS);

    logic                 accept;
    logic                 beat_valid;
    logic [WIDX_W-1:0]    beat_word;
    logic [CLS_W-1:0]     beat_class;
    logic                 beat_last;
    logic                 beat_final;
    logic [MAP_BITS-1:0]  test_map_q;
    logic [WORD_BITS-1:0] test_word;

    always_ff @(posedge clk) begin
        if (rst)         test_map_q <= '0;
        else if (accept) test_map_q <= test_map_i;
    end

    assign test_word = test_map_q[beat_word*WORD_BITS +: WORD_BITS];

    hm_read_sequencer #(.NUM_CLASSES(NUM_CLASSES), .WORDS(WORDS)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .accept_o     (accept),
        .rd_o         (tmpl_rd_o),
        .addr_o       (tmpl_addr_o),
        .beat_valid_o (beat_valid),
        .beat_word_o  (beat_word),
        .beat_class_o (beat_class),
        .beat_last_o  (beat_last),
        .beat_final_o (beat_final)
    );

    hm_min_tracker #(
        .NUM_CLASSES (NUM_CLASSES),
        .MAP_BITS    (MAP_BITS),
        .WORD_BITS   (WORD_BITS)
    ) u_track (
        .clk          (clk),
        .rst          (rst),
        .beat_valid_i (beat_valid),
        .beat_class_i (beat_class),
        .beat_last_i  (beat_last),
        .beat_final_i (beat_final),
        .test_word_i  (test_word),
        .tmpl_word_i  (tmpl_data_i),
        .valid_o      (result_valid_o),
        .best_class_o (best_class_o),
        .best_count_o (best_count_o)
    );

    // R9
    map_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(test_map_q));
endmodule

// File: tb/hamming_class_matcher_test.sv
module hamming_class_matcher_test;
    localparam int NC = 4;
    localparam int MB = 64;
    localparam int WB = 16;
    localparam int NW = MB / WB;
    localparam int T  = NC * NW;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [MB-1:0] test_map;
    logic          tmpl_rd_o;
    logic [3:0]    tmpl_addr_o;
    logic [WB-1:0] tmpl_data_i;
    logic          result_valid_o;
    logic [1:0]    best_class_o;
    logic [6:0]    best_count_o;

    logic [WB-1:0] mem [T];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #2 clk = ~clk;

    hamming_class_matcher #(.NUM_CLASSES(NC), .MAP_BITS(MB), .WORD_BITS(WB)) uut (
        .clk(clk), .rst(rst), .start_i(start), .test_map_i(test_map),
        .tmpl_rd_o(tmpl_rd_o), .tmpl_addr_o(tmpl_addr_o), .tmpl_data_i(tmpl_data_i),
        .result_valid_o(result_valid_o), .best_class_o(best_class_o),
        .best_count_o(best_count_o)
    );

    // R10: template memory answers one cycle after the request
    always @(posedge clk) if (tmpl_rd_o) tmpl_data_i <= mem[tmpl_addr_o];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    task automatic set_tmpl(input int c, input logic [MB-1:0] v);
        for (int w = 0; w < NW; w++) mem[c*NW + w] = v[w*WB +: WB];
    endtask

    task automatic calc(input logic [MB-1:0] tm, output int cls, output int cnt);
        cls = 0;
        cnt = MB + 1;
        for (int c = 0; c < NC; c++) begin
            logic [MB-1:0] t;
            int d;
            for (int w = 0; w < NW; w++) t[w*WB +: WB] = mem[c*NW + w];
            d = $countones(tm ^ t);
            if (d < cnt) begin cnt = d; cls = c; end
        end
    endtask

    // mode 0 plain, 1 start mid-burst (R8), 2 map change after start (R9),
    // 3 start in final scoring cycle (R8)
    task automatic run(input logic [MB-1:0] tm, input int mode, input string creq,
                       input bit chain, input logic [MB-1:0] nxt);
        int ec, en;
        calc(tm, ec, en);
        if (!start) begin
            @(negedge clk);
            test_map = tm;
            start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc <= T + 1; cyc++) begin
            if (cyc > 0) @(negedge clk);
            chk("R2 read enable", tmpl_rd_o, (cyc < T) ? 1 : 0);
            if (cyc < T) chk("R2 address", tmpl_addr_o, cyc);
            chk("R6 valid timing", result_valid_o, (cyc == T + 1) ? 1 : 0);
            if (cyc == T + 1) begin
                chk("R3 count", best_count_o, en);
                chk({creq, " class"}, best_class_o, ec);
            end
            if (mode == 1 && cyc == 1) begin start = 1'b1; test_map = ~tm; end
            if (mode == 1 && cyc == 2) start = 1'b0;
            if (mode == 2 && cyc == 2) test_map = ~tm;
            if (mode == 3 && cyc == T) begin start = 1'b1; test_map = ~tm; end
            if (mode == 3 && cyc == T + 1) start = 1'b0;
        end
        if (chain) begin
            test_map = nxt;
            start = 1'b1;
        end else begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R7 valid low", result_valid_o, 0);
                chk("R7 class hold", best_class_o, ec);
                chk("R7 count hold", best_count_o, en);
                chk("R8 no extra read", tmpl_rd_o, 0);
            end
        end
    endtask

    initial begin
        logic [MB-1:0] tm;
        rst = 1'b1;
        start = 1'b0;
        test_map = '0;
        for (int i = 0; i < T; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid", result_valid_o, 0);
        chk("R1 class", best_class_o, 0);
        chk("R1 count", best_count_o, 0);
        chk("R1 read", tmpl_rd_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after release", result_valid_o, 0);
        chk("R1 read after release", tmpl_rd_o, 0);

        // R4 sweep over pseudo-random maps and all stimulus modes
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < NC; c++) set_tmpl(c, next_rand());
            run(next_rand(), s % 4, "R4", 1'b0, '0);
        end

        // R5 tie between classes 1 and 3 at distance 4
        tm = 64'hA5C3_0F1E_7788_1234;
        set_tmpl(0, tm ^ 64'hFF);
        set_tmpl(1, tm ^ 64'h0F);
        set_tmpl(2, tm ^ 64'hFFFF);
        set_tmpl(3, tm ^ 64'hF0);
        run(tm, 0, "R5", 1'b0, '0);

        // R5 all classes equal
        for (int c = 0; c < NC; c++) set_tmpl(c, tm ^ 64'h8000_0000_0000_0001);
        run(tm, 0, "R5 all-equal", 1'b0, '0);

        // R3 maximum count, all classes fully opposite
        for (int c = 0; c < NC; c++) set_tmpl(c, ~tm);
        run(tm, 0, "R3 max", 1'b0, '0);

        // R4 last class wins with distance 1
        set_tmpl(3, tm ^ 64'h1);
        run(tm, 0, "R4 last", 1'b0, '0);

        // R3 exact match on class 2
        set_tmpl(2, tm);
        run(tm, 0, "R3 zero", 1'b0, '0);

        // R8 start in the valid cycle is accepted: chained passes
        run(tm, 0, "R8 chain first", 1'b1, ~tm);
        run(~tm, 0, "R8 chain second", 1'b0, '0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule